// File: doc/BRIEF.md
# Three-Register Point-to-Point Transfer Network

This block keeps three W-bit registers, numbered 0, 1 and 2. In front of each register sits a two-way source selector. The selector can pick only the other two registers, never its own. Each register has its own select bit and its own load-enable bit, so every register chooses its source and decides whether to update independently of the others. All loads happen on the same rising clock edge and read the values held before that edge. As a result, a single move, a swap of two registers, a rotation through all three, or a copy of one register into the other two each completes in one clock.

A synchronous initialisation port writes all three registers at once from dedicated data inputs. It takes precedence over any transfer and gives a test environment or a neighbouring block a way to set known contents. The block holds no state machine: its whole state is the three data registers. The active-low reset is asynchronous and clears all three registers to zero.

Top module: `xfer_p2p_regs`

## Requirements
- R1: While `rst_n` is low, all three register outputs are zero.
- R2: When `init_en_i` is 1 at a rising edge, registers 0, 1 and 2 take `init_r0_i`, `init_r1_i` and `init_r2_i` respectively, whatever `sel_i` and `ld_i` hold.
- R3: With `init_en_i` at 0, a register whose bit in `ld_i` is 0 keeps its value across the edge.
- R4: Register 2 loads when `ld_i[2]` is 1. Its source is register 1 if `sel_i[2]` is 1 and register 0 if `sel_i[2]` is 0.
- R5: Register 1 loads when `ld_i[1]` is 1. Its source is register 2 if `sel_i[1]` is 1 and register 0 if `sel_i[1]` is 0.
- R6: Register 0 loads when `ld_i[0]` is 1. Its source is register 1 if `sel_i[0]` is 1 and register 2 if `sel_i[0]` is 0.
- R7: All transfers in one cycle read the pre-edge values. With `sel_i`=3'b11x and `ld_i`=3'b110, registers 1 and 2 exchange contents in one clock.
- R8: With `sel_i`=3'b100 and `ld_i`=3'b111, register 2 takes register 1, register 1 takes register 0, and register 0 takes register 2, all in one clock.
- R9: With `sel_i`=3'b00x and `ld_i`=3'b110, the value of register 0 lands in both register 1 and register 2 in one clock, and register 0 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en_i | input | 1 | Synchronous initialisation of all registers; has priority |
| init_r0_i | input | W | Initialisation value for register 0 |
| init_r1_i | input | W | Initialisation value for register 1 |
| init_r2_i | input | W | Initialisation value for register 2 |
| sel_i | input | 3 | Per-register source select, bit k for register k |
| ld_i | input | 3 | Per-register load enable, bit k for register k |
| r0_o | output | W | Contents of register 0 |
| r1_o | output | W | Contents of register 1 |
| r2_o | output | W | Contents of register 2 |

## Verification
The bench aims at the cases in which two or three registers update on the same edge. Exchange and rotation go wrong if a register reads a value that was already updated in that cycle: the swap then leaves both registers equal, and the rotation smears one value across the registers. Each register's selector has its own polarity, and register 0 is the odd one because its select 1 picks the lower-numbered neighbour. A design that applied one polarity rule to all three would send the wrong source into register 0 during rotation and in the random traffic. The bench also drives initialisation with every load bit high and mixed selects, to catch a transfer that wins over initialisation. It checks idle load bits to catch registers that drift when they should hold.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int NREG = 3;
    localparam int IDXW = $clog2(NREG);

    // Source register feeding destination dst for a given select bit.
    function automatic logic [IDXW-1:0] src_of(input int dst, input logic s);
        logic [IDXW-1:0] r;
        unique case (dst)
            2:       r = s ? IDXW'(1) : IDXW'(0);
            1:       r = s ? IDXW'(2) : IDXW'(0);
            default: r = s ? IDXW'(1) : IDXW'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xfer_srcmux.sv
module xfer_srcmux
    import xfer_pkg::*;
#(
    parameter int W   = 8,
    parameter int DST = 0
) (
    input  logic [NREG-1:0][W-1:0] regs_i,
    input  logic                   sel_i,
    output logic [W-1:0]           data_o
);

    logic [IDXW-1:0] src_idx;

    always_comb begin
        src_idx = src_of(DST, sel_i);
        data_o  = regs_i[src_idx];
    end

    initial begin
        AST_NO_SELF_SOURCE_A: assert (src_of(DST, 1'b0) != IDXW'(DST)); // R7
        AST_NO_SELF_SOURCE_B: assert (src_of(DST, 1'b1) != IDXW'(DST)); // R7
    end

endmodule

// File: rtl/xfer_cell.sv
module xfer_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_en_i,
    input  logic [W-1:0] init_d_i,
    input  logic         ld_i,
    input  logic [W-1:0] bus_d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (init_en_i) begin
            q_o <= init_d_i;
        end else if (ld_i) begin
            q_o <= bus_d_i;
        end
    end

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en_i && !ld_i) |=> $stable(q_o)); // R3

    AST_CELL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        init_en_i |=> (q_o == $past(init_d_i))); // R2

endmodule

// File: rtl/xfer_p2p_regs.sv
module xfer_p2p_regs
    import xfer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_en_i,
    input  logic [W-1:0] init_r0_i,
    input  logic [W-1:0] init_r1_i,
    input  logic [W-1:0] init_r2_i,
    input  logic [2:0]   sel_i,
    input  logic [2:0]   ld_i,
    output logic [W-1:0] r0_o,
    output logic [W-1:0] r1_o,
    output logic [W-1:0] r2_o
);

    logic [NREG-1:0][W-1:0] cur_q;
    logic [NREG-1:0][W-1:0] init_d;
    logic [NREG-1:0][W-1:0] mux_d;

    assign init_d[0] = init_r0_i;
    assign init_d[1] = init_r1_i;
    assign init_d[2] = init_r2_i;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        xfer_srcmux #(.W(W), .DST(g)) u_mux (
            .regs_i (cur_q),
            .sel_i  (sel_i[g]),
            .data_o (mux_d[g])
        );

        xfer_cell #(.W(W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_en_i (init_en_i),
            .init_d_i  (init_d[g]),
            .ld_i      (ld_i[g]),
            .bus_d_i   (mux_d[g]),
            .q_o       (cur_q[g])
        );
    end

    assign r0_o = cur_q[0];
    assign r1_o = cur_q[1];
    assign r2_o = cur_q[2];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (r0_o == '0 && r1_o == '0 && r2_o == '0)); // R1

    AST_R2_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en_i && ld_i[2]) |=>
        (r2_o == ($past(sel_i[2]) ? $past(r1_o) : $past(r0_o)))); // R4

    AST_R1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en_i && ld_i[1]) |=>
        (r1_o == ($past(sel_i[1]) ? $past(r2_o) : $past(r0_o)))); // R5

    AST_R0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en_i && ld_i[0]) |=>
        (r0_o == ($past(sel_i[0]) ? $past(r1_o) : $past(r2_o)))); // R6

    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en_i && ld_i == 3'b111 && sel_i == 3'b100) |=>
        (r0_o == $past(r2_o) && r1_o == $past(r0_o) && r2_o == $past(r1_o))); // R8

endmodule

// File: tb/xfer_p2p_regs_bench.sv
module xfer_p2p_regs_bench;

    localparam int W      = 8;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         init_en_i;
    logic [W-1:0] init_r0_i, init_r1_i, init_r2_i;
    logic [2:0]   sel_i, ld_i;
    logic [W-1:0] r0_o, r1_o, r2_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [3];

    always #(CLK_NS/2) clk = ~clk;

    xfer_p2p_regs #(.W(W)) u_xfer_p2p_regs (
        .clk(clk), .rst_n(rst_n), .init_en_i(init_en_i),
        .init_r0_i(init_r0_i), .init_r1_i(init_r1_i), .init_r2_i(init_r2_i),
        .sel_i(sel_i), .ld_i(ld_i),
        .r0_o(r0_o), .r1_o(r1_o), .r2_o(r2_o)
    );

    task automatic chk(input string tag, input int idx, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, idx, act, exp);
        end
    endtask

    function automatic logic [W-1:0] out_of(input int k);
        if (k == 0) return r0_o;
        if (k == 1) return r1_o;
        return r2_o;
    endfunction

    // Called at a falling edge: apply inputs, predict, wait one edge, compare.
    task automatic step(input logic ie, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input logic [2:0] s, input logic [2:0] l,
                        input string tag);
        logic [W-1:0] nxt [3];
        logic [W-1:0] ini [3];
        ini[0] = a; ini[1] = b; ini[2] = c;
        init_en_i = ie; init_r0_i = a; init_r1_i = b; init_r2_i = c;
        sel_i = s; ld_i = l;
        for (int k = 0; k < 3; k++) begin
            if (ie) nxt[k] = ini[k];
            else if (!l[k]) nxt[k] = model[k];
            else if (k == 2) nxt[k] = s[2] ? model[1] : model[0];
            else if (k == 1) nxt[k] = s[1] ? model[2] : model[0];
            else nxt[k] = s[0] ? model[1] : model[2];
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            string t;
            if (tag != "") t = tag;
            else if (ie) t = "R2";
            else if (!l[k]) t = "R3";
            else if (k == 2) t = "R4";
            else if (k == 1) t = "R5";
            else t = "R6";
            model[k] = nxt[k];
            chk(t, k, out_of(k), nxt[k]);
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; init_en_i = 1'b1; sel_i = 3'b111; ld_i = 3'b111;
        init_r0_i = 8'hAA; init_r1_i = 8'hBB; init_r2_i = 8'hCC;
        @(negedge clk); @(negedge clk);
        chk("R1", 0, r0_o, '0); chk("R1", 1, r1_o, '0); chk("R1", 2, r2_o, '0);
        init_en_i = 1'b0; ld_i = 3'b000;
        for (int k = 0; k < 3; k++) model[k] = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2: initialisation wins over all load bits
        step(1'b1, 8'h11, 8'h22, 8'h33, 3'b101, 3'b111, "R2");
        // R3: nothing loads
        step(1'b0, 8'hFF, 8'hFF, 8'hFF, 3'b111, 3'b000, "R3");
        // R4: point-to-point move of register 1 into register 2
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b100, 3'b100, "R4");
        step(1'b1, 8'h11, 8'h22, 8'h33, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b000, 3'b100, "R4");
        step(1'b1, 8'h11, 8'h22, 8'h33, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b010, 3'b010, "R5");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b001, 3'b001, "R6");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b000, 3'b001, "R6");
        // R7: exchange of registers 1 and 2
        step(1'b1, 8'h5A, 8'hC3, 8'h96, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b110, 3'b110, "R7");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b111, 3'b110, "R7");
        // R8: rotation, three times returns to start
        step(1'b1, 8'h01, 8'h02, 8'h03, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b100, 3'b111, "R8");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b100, 3'b111, "R8");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b100, 3'b111, "R8");
        // R9: broadcast of register 0
        step(1'b1, 8'h7E, 8'h00, 8'hFF, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b000, 3'b110, "R9");
        step(1'b1, 8'h3C, 8'h81, 8'h42, 3'b000, 3'b000, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h00, 3'b001, 3'b110, "R9");

        // Random traffic, initialisation rare
        for (int i = 0; i < 400; i++) begin
            logic ie;
            ie = ($urandom_range(0, 15) == 0);
            step(ie, W'($urandom), W'($urandom), W'($urandom),
                 3'($urandom), 3'($urandom), "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule